// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register File

This block is the host-facing register file for a 48-line digital I/O bank. The lines form six 8-bit ports. Each line works either as an open-drain output or as an input. Writing a 1 to a port bit turns on that line's low-side driver, so the pin is pulled low. Writing a 0 releases the line, and an external pull-up can then take it high. A read of a port returns the complement of the pin level after a two-flop synchronizer, so a high pin reads as 0. A line used as an input keeps its port bit at 0, which leaves it released.

The host bus is synchronous and byte-wide, with a 4-bit offset. One combined register holds the page number in its top two bits and six per-port write-lock flags in its low bits. The page selects what appears in a three-byte window at the upper offsets:
- Page 0: nothing appears.
- Page 1: the edge polarity masks.
- Page 2: the edge enable masks.
- Page 3: the event-ID bytes of the separate edge-detect block. Writing one of these bytes sends a one-cycle clear strobe to that block.

The port data registers stay reachable on every page. A status byte summarises which event-ID bytes are non-zero.

Top module: `gpio_paged_regfile`

## Requirements
- R1: After reset, every port register, every lock flag and the page field are 0. `pin_pull_low`, `edge_pol`, `edge_en`, `id_clr_stb` and `host_rdata` are all 0.
- R2: A write to offset n (n = 0..5) loads port n. Port n bit b drives `pin_pull_low[8n+b]`, and a 1 means the line is pulled low. The new value shows on the outputs after the clock edge that takes the write.
- R3: A read of offset n returns the bitwise complement of `pin_level[8n+7:8n]` as sampled two clock edges before the edge that takes the read.
- R4: Offset 0x07 is the page/lock register. Bits 7:6 hold the page and bits 5:0 hold the lock flags, with bit n locking port n. It reads back as written.
- R5: While lock flag n is 1, writes to port n leave it unchanged. Reads of port n still return the pin level.
- R6: Port reads and writes behave the same on every page.
- R7: On page 1, offsets 0x08, 0x09 and 0x0A read and write polarity bytes 0, 1 and 2. These bytes drive `edge_pol[8k+7:8k]`.
- R8: On page 2, the same offsets read and write enable bytes 0..2. These bytes drive `edge_en`.
- R9: On page 3, a read of window byte k returns `irq_id[8k+7:8k]`. A write to window byte k raises only `id_clr_stb[k]` for the one cycle after the write edge, with the written byte on `id_clr_data`. Such a write changes neither `edge_pol` nor `edge_en`.
- R10: On page 0, window reads return 0x00. Window writes change nothing and raise no strobe.
- R11: A read of offset 0x06 returns, in bit k, the OR of `irq_id` byte k (k = 0..2), with bits 7:3 at 0. Writes to 0x06 have no effect.
- R12: Read data is registered. It appears after the edge that takes the read and holds until the next read. Offsets 0x0B to 0x0F read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Bus access in this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| pin_level | input | 48 | Sensed level of each line |
| pin_pull_low | output | 48 | Low-side driver enable for each line |
| edge_pol | output | 24 | Polarity masks for the edge-detect block |
| edge_en | output | 24 | Enable masks for the edge-detect block |
| irq_id | input | 24 | Event-ID bytes from the edge-detect block |
| id_clr_stb | output | 3 | One-cycle clear strobe per event-ID byte |
| id_clr_data | output | 8 | Data that goes with the clear strobe |

## Verification
The bench targets the following corner cases:
- Inversion on readback. A design that returned the raw level would read a high input as 0xFF instead of 0x00.
- The two-cycle synchronizer delay. A design with one stage, or with none, would show a new pin level one read too early.
- Lock flags. A locked port must not change. A design that gated reads, or applied a lock to the wrong port, would show a different read value or a different pin drive.
- The page window. Pages 0 and 3 are the risky cases: a design that sent page-3 writes into the masks, or accepted page-0 writes, would make `edge_pol` or `edge_en` drift from the reference model. The same traffic is repeated in a long random run across all pages and offsets, including the unmapped ones.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;

  localparam int BYTE_W   = 8;
  localparam int PAGE_W   = 2;
  localparam int PAGE_LSB = BYTE_W - PAGE_W;

  typedef enum logic [PAGE_W-1:0] {
    PG_IDLE     = 2'd0,
    PG_POLARITY = 2'd1,
    PG_ENABLE   = 2'd2,
    PG_EVENT_ID = 2'd3
  } page_e;

  // Open-drain readback: a high line reads as 0.
  function automatic logic [BYTE_W-1:0] level_to_reg(input logic [BYTE_W-1:0] lvl);
    return ~lvl;
  endfunction

  // Combined page/lock byte: page in the top bits, locks from bit 0 upward.
  function automatic logic [BYTE_W-1:0] pack_pglk(input page_e pg,
                                                  input logic [PAGE_LSB-1:0] locks);
    return {pg, locks};
  endfunction

  function automatic logic byte_any(input logic [BYTE_W-1:0] b);
    return |b;
  endfunction

endpackage

// File: rtl/gpio_pg_sync.sv
module gpio_pg_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  // Counts edges since reset so the delay check never looks before reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_q <= 2'd0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  assign q = stage2_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (q == $past(d, 2))); // R3

endmodule

// File: rtl/gpio_pg_ports.sv
module gpio_pg_ports #(
  parameter int NUM_PORTS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   wr_en,
  input  logic [7:0]             wdata,
  input  logic [NUM_PORTS-1:0]   lock,
  output logic [NUM_PORTS*8-1:0] drive
);

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    logic [7:0] data_q;
    logic       take;

    assign take = wr_en[n] && !lock[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    data_q <= 8'h00;
      else if (take) data_q <= wdata;
    end

    assign drive[n*8 +: 8] = data_q;

    AST_LOCKED_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[n] && lock[n]) |=> $stable(drive[n*8 +: 8])); // R5

    AST_OPEN_PORT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[n] && !lock[n]) |=> (drive[n*8 +: 8] == $past(wdata))); // R2
  end

endmodule

// File: rtl/gpio_pg_pagelock.sv
module gpio_pg_pagelock
  import gpio_pg_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wdata,
  output page_e                page,
  output logic [NUM_PORTS-1:0] lock,
  output logic [7:0]           view
);

  localparam int LOCK_FIELD = PAGE_LSB;

  page_e                page_q;
  logic [NUM_PORTS-1:0] lock_q;
  logic [LOCK_FIELD-1:0] lock_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PG_IDLE;
      lock_q <= '0;
    end else if (wr_en) begin
      page_q <= page_e'(wdata[7:PAGE_LSB]);
      lock_q <= wdata[NUM_PORTS-1:0];
    end
  end

  always_comb begin
    lock_field = '0;
    lock_field[NUM_PORTS-1:0] = lock_q;
  end

  assign page = page_q;
  assign lock = lock_q;
  assign view = pack_pglk(page_q, lock_field);

  AST_PGLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(view)); // R4

endmodule

// File: rtl/gpio_pg_window.sv
module gpio_pg_window
  import gpio_pg_pkg::*;
#(
  parameter int WIN_REGS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  page_e                 page,
  input  logic [WIN_REGS-1:0]   sel,
  input  logic                  wr,
  input  logic [7:0]            wdata,
  input  logic [WIN_REGS*8-1:0] evt_id,
  output logic [WIN_REGS*8-1:0] pol,
  output logic [WIN_REGS*8-1:0] en,
  output logic [WIN_REGS-1:0]   clr_stb,
  output logic [7:0]            clr_data,
  output logic [WIN_REGS*8-1:0] rd_vec
);

  logic [WIN_REGS-1:0] evt_wr;

  for (genvar k = 0; k < WIN_REGS; k++) begin : g_win
    logic [7:0] pol_q;
    logic [7:0] en_q;
    logic       wr_here;

    assign wr_here   = sel[k] && wr;
    assign evt_wr[k] = wr_here && (page == PG_EVENT_ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q <= 8'h00;
        en_q  <= 8'h00;
      end else if (wr_here) begin
        case (page)
          PG_POLARITY: pol_q <= wdata;
          PG_ENABLE:   en_q  <= wdata;
          default:     ;
        endcase
      end
    end

    always_comb begin
      case (page)
        PG_POLARITY: rd_vec[k*8 +: 8] = pol_q;
        PG_ENABLE:   rd_vec[k*8 +: 8] = en_q;
        PG_EVENT_ID: rd_vec[k*8 +: 8] = evt_id[k*8 +: 8];
        default:     rd_vec[k*8 +: 8] = 8'h00;
      endcase
    end

    assign pol[k*8 +: 8] = pol_q;
    assign en[k*8 +: 8]  = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_stb  <= '0;
      clr_data <= 8'h00;
    end else begin
      clr_stb <= evt_wr;
      if (|evt_wr) clr_data <= wdata;
    end
  end

  AST_PAGE0_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((page == PG_IDLE) && wr && (|sel)) |=> ($stable(pol) && $stable(en) && (clr_stb == '0))); // R10

  AST_IDSTB_ONLY_PAGE3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_stb) |-> ($past(page) == PG_EVENT_ID)); // R9

  AST_IDSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_stb)); // R9

endmodule

// File: rtl/gpio_paged_regfile.sv
module gpio_paged_regfile
  import gpio_pg_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int WIN_REGS  = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_req,
  input  logic                   host_we,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic [NUM_PORTS*8-1:0] pin_level,
  output logic [NUM_PORTS*8-1:0] pin_pull_low,
  output logic [WIN_REGS*8-1:0]  edge_pol,
  output logic [WIN_REGS*8-1:0]  edge_en,
  input  logic [WIN_REGS*8-1:0]  irq_id,
  output logic [WIN_REGS-1:0]    id_clr_stb,
  output logic [7:0]             id_clr_data
);

  localparam int LINES    = NUM_PORTS * BYTE_W;
  localparam int WIN_W    = WIN_REGS * BYTE_W;
  localparam int PEND_OFF = NUM_PORTS;
  localparam int PGLK_OFF = NUM_PORTS + 1;
  localparam int WIN_OFF  = NUM_PORTS + 2;

  // Decode events, brought out as named wires.
  logic                 rd_fire;
  logic                 wr_fire;
  logic [NUM_PORTS-1:0] port_hit;
  logic [NUM_PORTS-1:0] port_wr;
  logic [WIN_REGS-1:0]  win_hit;
  logic                 pend_hit;
  logic                 pglk_hit;
  logic                 pglk_wr;

  page_e                cur_page;
  logic [NUM_PORTS-1:0] cur_lock;
  logic [7:0]           pglk_view;
  logic [LINES-1:0]     lvl_sync;
  logic [WIN_W-1:0]     win_rd;
  logic [7:0]           pend_byte;
  logic [7:0]           rd_next;
  logic [7:0]           rdata_q;

  assign rd_fire  = host_req && !host_we;
  assign wr_fire  = host_req && host_we;
  assign pend_hit = (int'(host_addr) == PEND_OFF);
  assign pglk_hit = (int'(host_addr) == PGLK_OFF);
  assign pglk_wr  = wr_fire && pglk_hit;

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port_dec
    assign port_hit[n] = (int'(host_addr) == n);
    assign port_wr[n]  = wr_fire && port_hit[n];
  end

  for (genvar k = 0; k < WIN_REGS; k++) begin : g_win_dec
    assign win_hit[k] = (int'(host_addr) == WIN_OFF + k);
  end

  gpio_pg_sync #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_level),
    .q     (lvl_sync)
  );

  gpio_pg_pagelock #(.NUM_PORTS(NUM_PORTS)) u_pglk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pglk_wr),
    .wdata (host_wdata),
    .page  (cur_page),
    .lock  (cur_lock),
    .view  (pglk_view)
  );

  gpio_pg_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (port_wr),
    .wdata (host_wdata),
    .lock  (cur_lock),
    .drive (pin_pull_low)
  );

  gpio_pg_window #(.WIN_REGS(WIN_REGS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .page     (cur_page),
    .sel      (win_hit),
    .wr       (wr_fire),
    .wdata    (host_wdata),
    .evt_id   (irq_id),
    .pol      (edge_pol),
    .en       (edge_en),
    .clr_stb  (id_clr_stb),
    .clr_data (id_clr_data),
    .rd_vec   (win_rd)
  );

  // Pending summary: one bit per event-ID byte.
  always_comb begin
    pend_byte = 8'h00;
    for (int k = 0; k < WIN_REGS; k++) begin
      pend_byte[k] = byte_any(irq_id[k*8 +: 8]);
    end
  end

  always_comb begin
    rd_next = 8'h00;
    for (int n = 0; n < NUM_PORTS; n++) begin
      if (port_hit[n]) rd_next = level_to_reg(lvl_sync[n*8 +: 8]);
    end
    for (int k = 0; k < WIN_REGS; k++) begin
      if (win_hit[k]) rd_next = win_rd[k*8 +: 8];
    end
    if (pend_hit) rd_next = pend_byte;
    if (pglk_hit) rd_next = pglk_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= 8'h00;
    else if (rd_fire) rdata_q <= rd_next;
  end

  assign host_rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(host_rdata)); // R12

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({port_hit, win_hit, pend_hit, pglk_hit}) <= 1); // R12

endmodule

// File: tb/tb_gpio_paged_regfile.sv
`timescale 1ns/1ps
module tb_gpio_paged_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic [47:0] ext_level = '1;
  logic [47:0] pin_level;
  logic [47:0] pin_pull_low;
  logic [23:0] edge_pol;
  logic [23:0] edge_en;
  logic [23:0] irq_id = '0;
  logic [2:0]  id_clr_stb;
  logic [7:0]  id_clr_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit armed = 0;

  always #2.5 clk = ~clk;

  // Open-drain line: low when driven, else whatever the outside world holds.
  assign pin_level = ext_level & ~pin_pull_low;

  gpio_paged_regfile dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pin_level(pin_level), .pin_pull_low(pin_pull_low), .edge_pol(edge_pol),
    .edge_en(edge_en), .irq_id(irq_id), .id_clr_stb(id_clr_stb),
    .id_clr_data(id_clr_data)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_port [6];
  logic [7:0]  m_pol  [3];
  logic [7:0]  m_en   [3];
  logic [1:0]  m_page;
  logic [5:0]  m_lock;
  logic [47:0] m_s1, m_s2;
  logic [7:0]  m_rd;
  logic [2:0]  m_stb;
  logic [7:0]  m_clr;
  string       rd_tag = "R1";
  string       pl_tag = "R1";

  function automatic logic [47:0] m_drive();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = m_port[i];
    return v;
  endfunction

  function automatic logic [23:0] m_join(input bit pick_pol);
    logic [23:0] v;
    for (int i = 0; i < 3; i++) v[i*8 +: 8] = pick_pol ? m_pol[i] : m_en[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_port[i] = 8'h00;
      for (int i = 0; i < 3; i++) begin m_pol[i] = 8'h00; m_en[i] = 8'h00; end
      m_page = 2'd0; m_lock = 6'd0; m_s1 = '0; m_s2 = '0;
      m_rd = 8'h00; m_stb = 3'b000; m_clr = 8'h00;
    end else begin
      int a;
      a = int'(host_addr);
      m_stb = 3'b000;
      if (host_req && !host_we) begin
        if (a < 6) begin
          m_rd = ~m_s2[a*8 +: 8];
          rd_tag = m_lock[a] ? "R5" : (m_page != 0 ? "R6" : "R3");
        end else if (a == 6) begin
          m_rd = {5'b0, |irq_id[23:16], |irq_id[15:8], |irq_id[7:0]};
          rd_tag = "R11";
        end else if (a == 7) begin
          m_rd = {m_page, m_lock}; rd_tag = "R4";
        end else if (a < 11) begin
          case (m_page)
            2'd1: begin m_rd = m_pol[a-8]; rd_tag = "R7"; end
            2'd2: begin m_rd = m_en[a-8];  rd_tag = "R8"; end
            2'd3: begin m_rd = irq_id[(a-8)*8 +: 8]; rd_tag = "R9"; end
            default: begin m_rd = 8'h00; rd_tag = "R10"; end
          endcase
        end else begin
          m_rd = 8'h00; rd_tag = "R12";
        end
      end
      if (host_req && host_we) begin
        if (a < 6) begin
          if (m_lock[a]) pl_tag = "R5";
          else begin
            m_port[a] = host_wdata;
            pl_tag = (m_page != 0) ? "R6" : "R2";
          end
        end else if (a == 7) begin
          m_page = host_wdata[7:6]; m_lock = host_wdata[5:0];
        end else if (a >= 8 && a < 11) begin
          case (m_page)
            2'd1: m_pol[a-8] = host_wdata;
            2'd2: m_en[a-8] = host_wdata;
            2'd3: begin m_stb[a-8] = 1'b1; m_clr = host_wdata; end
            default: ;
          endcase
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_level;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the edge.
  always @(negedge clk) begin
    if (armed && rst_n && !done) begin
      chk(pl_tag, "pin_pull_low", 64'(pin_pull_low), 64'(m_drive()));
      chk("R7", "edge_pol", 64'(edge_pol), 64'(m_join(1'b1)));
      chk("R8", "edge_en", 64'(edge_en), 64'(m_join(1'b0)));
      chk("R9", "id_clr_stb", 64'(id_clr_stb), 64'(m_stb));
      if (m_stb != 0) chk("R9", "id_clr_data", 64'(id_clr_data), 64'(m_clr));
      chk(rd_tag, "host_rdata", 64'(host_rdata), 64'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input bit we, input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = data;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    chk("R1", "reset pull_low", 64'(pin_pull_low), 64'h0);
    chk("R1", "reset rdata", 64'(host_rdata), 64'h0);
    chk("R1", "reset pol/en", 64'({edge_pol, edge_en}), 64'h0);
    chk("R1", "reset stb", 64'(id_clr_stb), 64'h0);
    armed = 1'b1;
    bus(1'b0, 4'h7, 8'h00);                 // R1: page/lock reads 0

    bus(1'b1, 4'h0, 8'hA5);                 // R2
    bus(1'b1, 4'h5, 8'h3C);
    idle(3);
    bus(1'b0, 4'h0, 8'h00);                 // R3: expect 0xA5
    bus(1'b0, 4'h5, 8'h00);
    ext_level[15:8] = 8'h0F;                // input port driven from outside
    bus(1'b0, 4'h1, 8'h00);                 // R3: still old level (sync delay)
    idle(3);
    bus(1'b0, 4'h1, 8'h00);                 // R3: expect 0xF0

    bus(1'b1, 4'h7, 8'h41);                 // R4: page 1, lock port 0
    bus(1'b0, 4'h7, 8'h00);
    bus(1'b1, 4'h0, 8'hFF);                 // R5: ignored
    idle(3);
    bus(1'b0, 4'h0, 8'h00);                 // R5: read works
    bus(1'b1, 4'h2, 8'h81);                 // R6: port write on page 1
    idle(3);
    bus(1'b0, 4'h2, 8'h00);

    bus(1'b1, 4'h8, 8'h11);                 // R7
    bus(1'b1, 4'h9, 8'h22);
    bus(1'b1, 4'hA, 8'h33);
    bus(1'b0, 4'h9, 8'h00);
    bus(1'b1, 4'h7, 8'h80);                 // R8: page 2
    bus(1'b1, 4'h8, 8'hE1);
    bus(1'b1, 4'hA, 8'h7E);
    bus(1'b0, 4'hA, 8'h00);
    bus(1'b1, 4'h7, 8'hC0);                 // R9: page 3
    irq_id = 24'h00_40_05;
    bus(1'b0, 4'h8, 8'h00);
    bus(1'b0, 4'h9, 8'h00);
    bus(1'b0, 4'h6, 8'h00);                 // R11: expect 0x03
    bus(1'b1, 4'h6, 8'hFF);                 // R11: write ignored
    bus(1'b1, 4'h9, 8'h40);                 // R9: strobe on byte 1
    bus(1'b1, 4'h7, 8'h00);                 // R10: page 0
    bus(1'b1, 4'h8, 8'h99);
    bus(1'b0, 4'h8, 8'h00);
    bus(1'b1, 4'hC, 8'h55);                 // R12: unmapped
    bus(1'b0, 4'hF, 8'h00);
    idle(2);                                // R12: rdata holds

    for (int i = 0; i < 600; i++) begin
      if ((i % 7) == 0) ext_level = {$urandom(), $urandom()};
      if ((i % 11) == 0) irq_id = 24'($urandom());
      bus(1'($urandom()), 4'($urandom()), 8'($urandom()));
    end
    idle(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule